// File: doc/BRIEF.md
# Banked Control Register File

This block is the control register store of a network controller. Its host-facing port is a synchronous register port, as a serial command decoder would drive it. The port has a 5-bit address, 8-bit write and read data, and separate write and read strobes. The 32-address space is split in two. The lower addresses are banked: the storage reached there depends on a 2-bit bank number. The highest addresses form a common window, and every bank sees the same registers there. The bank number is itself held in the last common register, so software can always reach it and change it.

Bank 0 holds eight 13-bit pointers into an 8 KB packet buffer, each stored as a low byte and a high byte. The block drives these pointers out continuously so the buffer logic can use them. The packet buffer memory and the PHY registers have their own access paths and cannot be reached through this port.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every implemented register holds 00h, bank 0 is selected, all exported pointers are zero, and `reg_rvalid` is low.
- R2: A read strobe in cycle N gives `reg_rvalid` high and the read data on `reg_rdata` in cycle N+1. With no read strobe in cycle N, `reg_rvalid` is low and `reg_rdata` is 00h in cycle N+1.
- R3: Bits [1:0] of the common register at address 1Fh select the bank (00, 01, 10, 11). Bits [7:2] of that register are plain read/write storage. A write to 1Fh steers the very next access to the new bank.
- R4: In each bank, addresses 00h to 0Fh are storage of that bank alone. A write in one bank never changes the value read at the same address in another bank.
- R5: Addresses 1Ah to 1Fh reach the same six registers whichever bank is selected.
- R6: In bank 0, pointer k (k = 0..7) has its low byte at address 2k and its high byte at address 2k+1. `buf_ptrs[13k+12:13k]` equals {high[4:0], low[7:0]} from the edge that completes the write.
- R7: Bits [7:5] of every pointer high byte (odd addresses 01h to 0Fh of bank 0) read as 0, and writes to those bits are ignored.
- R8: Addresses 10h to 19h are unimplemented in every bank. They read as 00h, and writes to them change no register.
- R9: When a read and a write arrive in the same cycle, the read returns the value held before that write. The address is resolved with the bank that was selected before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address within the current bank |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| reg_rvalid | output | 1 | High in the cycle that `reg_rdata` carries read data |
| buf_ptrs | output | 104 | Eight 13-bit buffer pointers from bank 0, pointer k at bits [13k+12:13k] |

## Verification
A read and a write can fall in the same cycle. This matters most when the write targets the bank-select register and the read targets a banked address, or when both hit the same register. The bench provokes these cases with directed pairs and by random strobes that are often asserted together. The bench model computes each expected read before it applies the write of that cycle. Any design that forwards write data, or that switches bank within the cycle, is therefore reported.

// File: rtl/brf_pkg.sv
package brf_pkg;

   // Which part of the 32-address space an access lands in
   typedef enum logic [1:0] {
      RGN_BANKED = 2'd0,
      RGN_COMMON = 2'd1,
      RGN_UNIMPL = 2'd2
   } region_e;

endpackage

// File: rtl/brf_decode.sv
module brf_decode
   import brf_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int COMMON_FIRST = 26,
   parameter int BANKED_IMPL  = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   localparam logic [ADDR_W-1:0] COMMON_LO = ADDR_W'(COMMON_FIRST);
   localparam logic [ADDR_W-1:0] IMPL_END  = ADDR_W'(BANKED_IMPL);

   always_comb begin
      if (addr >= COMMON_LO)
         region = RGN_COMMON;
      else if (addr < IMPL_END)
         region = RGN_BANKED;
      else
         region = RGN_UNIMPL;
   end

endmodule

// File: rtl/brf_plain_bank.sv
module brf_plain_bank #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else if (we) begin
         for (int k = 0; k < DEPTH; k++)
            if (addr == ADDR_W'(k)) mem_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < DEPTH; k++)
         if (addr == ADDR_W'(k)) rdata = mem_q[k];
   end

endmodule

// File: rtl/brf_ptr_bank.sv
module brf_ptr_bank #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int NUM_PTRS = 8,
   parameter int PTR_W    = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_PTRS*PTR_W-1:0] ptrs
);

   localparam int HI_W = PTR_W - DATA_W;

   logic [DATA_W-1:0] lo_q [NUM_PTRS];
   logic [HI_W-1:0]   hi_q [NUM_PTRS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_PTRS; k++) begin
            lo_q[k] <= '0;
            hi_q[k] <= '0;
         end
      end else if (we) begin
         for (int k = 0; k < NUM_PTRS; k++) begin
            if (addr == ADDR_W'(2 * k))     lo_q[k] <= wdata;
            if (addr == ADDR_W'(2 * k + 1)) hi_q[k] <= wdata[HI_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_PTRS; k++) begin
         if (addr == ADDR_W'(2 * k))     rdata = lo_q[k];
         if (addr == ADDR_W'(2 * k + 1)) rdata = DATA_W'(hi_q[k]);
      end
   end

   for (genvar k = 0; k < NUM_PTRS; k++) begin : g_export
      assign ptrs[k*PTR_W +: PTR_W] = {hi_q[k], lo_q[k]};
   end

endmodule

// File: rtl/brf_common.sv
module brf_common #(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 8,
   parameter int COMMON_FIRST = 26,
   parameter int BANK_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [BANK_W-1:0] bank_sel
);

   localparam int NUM_COMMON = (1 << ADDR_W) - COMMON_FIRST;

   logic [DATA_W-1:0] reg_q [NUM_COMMON];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_COMMON; k++) reg_q[k] <= '0;
      end else if (we) begin
         for (int k = 0; k < NUM_COMMON; k++)
            if (addr == ADDR_W'(COMMON_FIRST + k)) reg_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_COMMON; k++)
         if (addr == ADDR_W'(COMMON_FIRST + k)) rdata = reg_q[k];
   end

   // topmost common register carries the bank number
   assign bank_sel = reg_q[NUM_COMMON-1][BANK_W-1:0];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import brf_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 8,
   parameter int NUM_BANKS    = 4,
   parameter int COMMON_FIRST = 26,
   parameter int BANKED_IMPL  = 16,
   parameter int PTR_W        = 13,
   localparam int NUM_PTRS    = BANKED_IMPL / 2,
   localparam int PTRS_W      = NUM_PTRS * PTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic [PTRS_W-1:0] buf_ptrs
);

   localparam int BANK_W = $clog2(NUM_BANKS);

   if (BANKED_IMPL > COMMON_FIRST) begin : g_bad_impl
      $error("banked storage overlaps the common window");
   end
   if (COMMON_FIRST >= (1 << ADDR_W)) begin : g_bad_common
      $error("common window is empty");
   end
   if (PTR_W <= DATA_W || PTR_W > 2 * DATA_W) begin : g_bad_ptr
      $error("pointer width must span two bytes");
   end
   if ((BANKED_IMPL % 2) != 0) begin : g_bad_pairs
      $error("banked depth must hold whole pointer pairs");
   end
   if ((1 << BANK_W) != NUM_BANKS || DATA_W < BANK_W) begin : g_bad_banks
      $error("bank count must be a power of two fitting the data width");
   end

   region_e           region;
   logic [BANK_W-1:0] bank_sel;
   logic [DATA_W-1:0] common_rd;
   logic [DATA_W-1:0] bank_rd [NUM_BANKS];
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   brf_decode #(
      .ADDR_W       (ADDR_W),
      .COMMON_FIRST (COMMON_FIRST),
      .BANKED_IMPL  (BANKED_IMPL)
   ) decode_i (
      .addr   (reg_addr),
      .region (region)
   );

   brf_common #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .COMMON_FIRST (COMMON_FIRST),
      .BANK_W       (BANK_W)
   ) common_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_wr && region == RGN_COMMON),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (common_rd),
      .bank_sel (bank_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_we;
      assign bank_we = reg_wr && region == RGN_BANKED && bank_sel == BANK_W'(b);

      if (b == 0) begin : g_ptr
         brf_ptr_bank #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .NUM_PTRS (NUM_PTRS),
            .PTR_W    (PTR_W)
         ) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .rdata (bank_rd[b]),
            .ptrs  (buf_ptrs)
         );
      end else begin : g_plain
         brf_plain_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .DEPTH  (BANKED_IMPL)
         ) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .rdata (bank_rd[b])
         );
      end
   end

   // read mux uses pre-edge state, so a same-cycle write is not forwarded
   always_comb begin
      rd_mux = '0;
      unique case (region)
         RGN_COMMON: rd_mux = common_rd;
         RGN_BANKED: begin
            for (int b = 0; b < NUM_BANKS; b++)
               if (bank_sel == BANK_W'(b)) rd_mux = bank_rd[b];
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rdata_q  <= reg_rd ? rd_mux : '0;
         rvalid_q <= reg_rd;
      end
   end

   assign reg_rdata  = rdata_q;
   assign reg_rvalid = rvalid_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 8,
   parameter int BANK_W       = 2,
   parameter int COMMON_FIRST = 26,
   parameter int BANKED_IMPL  = 16,
   parameter int PTR_W        = 13,
   parameter int PTRS_W       = 104
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              reg_rvalid,
   input logic [PTRS_W-1:0] buf_ptrs,
   input logic [BANK_W-1:0] bank_sel
);

   localparam logic [ADDR_W-1:0] SEL_ADDR  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] IMPL_END  = ADDR_W'(BANKED_IMPL);
   localparam logic [ADDR_W-1:0] COMMON_LO = ADDR_W'(COMMON_FIRST);

   // R2
   rd_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   // R2
   no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rvalid |-> reg_rdata == '0);

   // R3
   bank_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_sel) |-> $past(reg_wr && reg_addr == SEL_ADDR));

   // R6
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(buf_ptrs) |-> $past(reg_wr && bank_sel == '0 && reg_addr < IMPL_END));

   // R7
   hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rd && bank_sel == '0 && reg_addr < IMPL_END && reg_addr[0])
      |-> reg_rdata[DATA_W-1:PTR_W-DATA_W] == '0);

   // R8
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rd && reg_addr >= IMPL_END && reg_addr < COMMON_LO)
      |-> reg_rdata == '0);

endmodule

bind banked_regfile banked_regfile_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .BANK_W       (BANK_W),
   .COMMON_FIRST (COMMON_FIRST),
   .BANKED_IMPL  (BANKED_IMPL),
   .PTR_W        (PTR_W),
   .PTRS_W       (PTRS_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .buf_ptrs   (buf_ptrs),
   .bank_sel   (bank_sel)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [7:0]   reg_wdata = '0;
   logic         reg_wr = 1'b0;
   logic         reg_rd = 1'b0;
   logic [7:0]   reg_rdata;
   logic         reg_rvalid;
   logic [103:0] buf_ptrs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_bank [4][16];
   logic [7:0] m_com  [6];

   always #10 clk = ~clk;

   banked_regfile dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .buf_ptrs   (buf_ptrs)
   );

   function automatic logic [7:0] exp_read(input logic [4:0] a);
      logic [1:0] b;
      b = m_com[5][1:0];
      if (a >= 5'd26) return m_com[a - 5'd26];
      if (a >= 5'd16) return 8'h00;
      return m_bank[b][a[3:0]];
   endfunction

   function automatic void model_write(input logic [4:0] a, input logic [7:0] d);
      logic [1:0] b;
      b = m_com[5][1:0];
      if (a >= 5'd26) m_com[a - 5'd26] = d;
      else if (a < 5'd16) m_bank[b][a[3:0]] = (b == 2'd0 && a[0]) ? (d & 8'h1F) : d;
   endfunction

   function automatic logic [103:0] exp_ptrs();
      logic [103:0] v;
      for (int k = 0; k < 8; k++)
         v[k*13 +: 13] = {m_bank[0][2*k+1][4:0], m_bank[0][2*k]};
      return v;
   endfunction

   task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic op(input bit wr, input bit rd, input logic [4:0] a,
                     input logic [7:0] d, input string tag);
      logic [7:0] e;
      e = exp_read(a);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
      if (wr) model_write(a, d);
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      if (rd) begin
         chk({tag, " rvalid R2"}, 104'(reg_rvalid), 104'(1));
         chk(tag, 104'(reg_rdata), 104'(e));
      end else begin
         chk("R2 idle rvalid/rdata", 104'({reg_rvalid, reg_rdata}), 104'(0));
      end
      if (wr) chk({tag, " ptrs R6"}, buf_ptrs, exp_ptrs());
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int b = 0; b < 4; b++)
         for (int k = 0; k < 16; k++) m_bank[b][k] = 8'h00;
      for (int k = 0; k < 6; k++) m_com[k] = 8'h00;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rvalid in reset", 104'(reg_rvalid), 104'(0));
      chk("R1 pointers in reset", buf_ptrs, 104'(0));
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 32; a++) op(1'b0, 1'b1, 5'(a), 8'h00, "R1 reset value");

      // R6 R7 pointer bytes and high-byte mask in bank 0
      op(1'b1, 1'b0, 5'h00, 8'hA5, "R6 ptr0 lo");
      op(1'b1, 1'b0, 5'h01, 8'hFF, "R7 ptr0 hi");
      op(1'b0, 1'b1, 5'h01, 8'h00, "R7 hi readback");
      op(1'b1, 1'b0, 5'h0F, 8'hE3, "R7 ptr7 hi");
      op(1'b1, 1'b0, 5'h0E, 8'h3C, "R6 ptr7 lo");
      op(1'b0, 1'b1, 5'h0F, 8'h00, "R7 ptr7 readback");

      // R3 R4 switch bank, same address holds separate data
      op(1'b1, 1'b0, 5'h1F, 8'hC1, "R3 select bank1");
      op(1'b0, 1'b1, 5'h00, 8'h00, "R4 bank1 fresh");
      op(1'b1, 1'b0, 5'h00, 8'h77, "R4 bank1 write");
      op(1'b0, 1'b1, 5'h1F, 8'h00, "R3 select readback");
      op(1'b1, 1'b0, 5'h1F, 8'h00, "R3 back to bank0");
      op(1'b0, 1'b1, 5'h00, 8'h00, "R4 bank0 kept");
      chk("R6 ptrs after other-bank write", buf_ptrs, exp_ptrs());

      // R5 common window alias
      op(1'b1, 1'b0, 5'h1F, 8'h02, "R3 select bank2");
      op(1'b1, 1'b0, 5'h1A, 8'h5A, "R5 common write");
      op(1'b1, 1'b0, 5'h1F, 8'h03, "R3 select bank3");
      op(1'b0, 1'b1, 5'h1A, 8'h00, "R5 common alias");

      // R8 unimplemented addresses
      op(1'b1, 1'b0, 5'h12, 8'hAA, "R8 unimpl write");
      op(1'b0, 1'b1, 5'h12, 8'h00, "R8 unimpl read");
      op(1'b0, 1'b1, 5'h19, 8'h00, "R8 unimpl top");
      op(1'b0, 1'b1, 5'h02, 8'h00, "R8 neighbour untouched");

      // R9 same-cycle read and write
      op(1'b1, 1'b0, 5'h05, 8'h11, "R9 seed");
      op(1'b1, 1'b1, 5'h05, 8'h22, "R9 read old value");
      op(1'b0, 1'b1, 5'h05, 8'h00, "R9 new value");
      op(1'b1, 1'b1, 5'h1F, 8'h01, "R9 select read old");
      op(1'b0, 1'b1, 5'h05, 8'h00, "R3 R9 next access bank1");

      // random mix
      for (int i = 0; i < 800; i++) begin
         logic [4:0] a;
         bit w, r;
         a = 5'($urandom_range(0, 31));
         if ($urandom_range(0, 7) == 0) a = 5'h1F;
         w = ($urandom_range(0, 2) != 0);
         r = ($urandom_range(0, 2) != 0);
         op(w, r, a, 8'($urandom), "R4/R5/R9 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule